// File: doc/BRIEF.md
# USB device transmit endpoint control and status

This block holds the control/status byte and the IN-token decision logic for one transmit endpoint of a USB device controller. The CPU reads and writes a byte-wide register. Some of its bits are commands that act once when written as 1. Others are flags that hardware sets and software clears. The serial engine of the controller reports IN tokens, acknowledged packets and frame starts as one-cycle pulses.

For every IN token the block answers, one cycle later, with one of three responses: send data, send a STALL handshake, or report that nothing was queued. It also keeps the DATA0/DATA1 toggle and tracks how many packets sit in the transmit FIFO. The FIFO holds one packet, or two when double buffering is enabled. The FIFO itself is modelled only by that count and by a pointer-reset strobe.

For high-bandwidth isochronous endpoints the block counts the parts of a split packet. It flags a packet that was not fully sent by the time the next frame starts.

Top module: `usb_in_ep_ctl`

## Requirements
- R1: After reset the register reads 0x00, the data toggle is 0, and `rsp_vld`, `fifo_ptr_rst` and `irq` are 0.
- R2: The register reads, from bit 7 down to bit 0: incomplete-iso, 0, stall-sent, stall-request, 0, underrun, fifo-not-empty, packet-ready. Bits 6 and 3 are commands that always read 0.
- R3: A write with bit 0 set and bit 3 clear loads a packet if the queue holds fewer than the limit (1, or 2 with `cfg_dbl`). Packet-ready then reads 1 only if the queue is now full. A load into a full queue is ignored.
- R4: A `tx_done` pulse removes one queued packet and clears packet-ready. It pulses `irq` on the next cycle when `cfg_irq_en` is 1, and it flips the data toggle unless `cfg_iso` is 1.
- R5: A write with bit 6 set forces the data toggle to 0. This wins over a flip in the same cycle.
- R6: When stall-request is 1 and `cfg_iso` is 0, an IN token gets response code 2 (STALL). Stall-sent then sets, the queue empties, packet-ready clears and `fifo_ptr_rst` pulses. With `cfg_iso` at 1, stall-request is ignored.
- R7: A write with bit 3 set pulses `fifo_ptr_rst`, clears packet-ready and pulses `irq` when enabled. If bit 0 is also written, only the packet being loaded is dropped. Otherwise the most recent queued packet is removed.
- R8: An IN token with no packet queued (and no stall) gets response code 3 (EMPTY) and sets underrun. A token with a packet queued gets code 1 (DATA). `rsp_vld` is high for exactly the cycle after each token. The code is 0 when no token came.
- R9: Stall-sent, underrun and incomplete-iso are cleared by writing 0 to their bit. Writing 1 to them has no effect. A hardware set in the same cycle as a software clear leaves the bit at 1.
- R10: With `cfg_iso` at 1 and `cfg_parts` above 1, each DATA response advances a part counter that wraps after `cfg_parts` parts. A `sof_evt` while the counter is nonzero sets incomplete-iso and resets the counter. In any other mode bit 7 reads 0.
- R11: Fifo-not-empty reads 1 exactly when at least one packet is queued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| cpu_wr | input | 1 | Register write strobe |
| cpu_wdata | input | 8 | Register write data |
| cpu_rdata | output | 8 | Register read data |
| cfg_iso | input | 1 | Endpoint is isochronous |
| cfg_parts | input | PART_W | Parts per packet in high-bandwidth isochronous mode |
| cfg_dbl | input | 1 | Double buffering enable |
| cfg_irq_en | input | 1 | Interrupt enable |
| in_tok | input | 1 | IN token received |
| tx_done | input | 1 | Data packet sent and acknowledged |
| sof_evt | input | 1 | Start of frame |
| rsp_vld | output | 1 | Response valid |
| rsp_code | output | 2 | 1 DATA, 2 STALL, 3 EMPTY, 0 none |
| data_tog | output | 1 | Current data PID toggle |
| fifo_ptr_rst | output | 1 | FIFO pointer reset strobe |
| irq | output | 1 | Interrupt pulse |

## Verification
The assertions assume that the controller never reports `tx_done` in the same cycle as an IN token and never reports it with an empty queue. They also assume that `sof_evt` does not coincide with a token, and that configuration inputs change only while reset is held. The random stimulus raises `tx_done` only when the bench's own model holds a queued packet and no token is being driven, and it suppresses `sof_evt` in token cycles. Configuration is changed only inside the reset task, so every random phase runs under a fixed mode.

// File: rtl/usb_inep_pkg.sv
package usb_inep_pkg;
  typedef enum logic [1:0] {
    RSP_NONE  = 2'd0,
    RSP_DATA  = 2'd1,
    RSP_STALL = 2'd2,
    RSP_EMPTY = 2'd3
  } rsp_e;

  // register bit positions (software decodes these)
  localparam int B_PKTRDY   = 0;
  localparam int B_NEMPTY   = 1;
  localparam int B_UNDER    = 2;
  localparam int B_FLUSH    = 3;
  localparam int B_STALLREQ = 4;
  localparam int B_STALLED  = 5;
  localparam int B_TOGCLR   = 6;
  localparam int B_INCOMP   = 7;

  // hardware-set / software-clear flag: set wins over clear
  function automatic logic sticky_next(logic cur, logic hw_set, logic sw_wr, logic sw_bit);
    if (hw_set) return 1'b1;
    if (sw_wr && !sw_bit) return 1'b0;
    return cur;
  endfunction
endpackage

// File: rtl/usb_inep_bufcnt.sv
module usb_inep_bufcnt #(
  parameter int MAX_PKTS = 2,
  localparam int CNT_W = $clog2(MAX_PKTS + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_dbl,
  input  logic             load_req,
  input  logic             flush_req,
  input  logic             abort_req,
  input  logic             done_evt,
  input  logic             stall_evt,
  output logic [CNT_W-1:0] cnt,
  output logic             pkt_rdy,
  output logic             ptr_rst
);
  localparam logic [CNT_W-1:0] MAX_C = CNT_W'(MAX_PKTS);
  localparam logic [CNT_W-1:0] ONE_C = CNT_W'(1);

  function automatic logic [CNT_W-1:0] dec_sat(logic [CNT_W-1:0] v, logic en);
    return (en && v != '0) ? v - ONE_C : v;
  endfunction

  logic [CNT_W-1:0] cnt_q, cnt_d, lim, after_tx, after_fl;
  logic             rdy_q, rdy_d, load_ok, ptr_q;

  always_comb begin
    lim      = cfg_dbl ? MAX_C : ONE_C;
    after_tx = dec_sat(cnt_q, done_evt);
    after_fl = dec_sat(after_tx, flush_req && !abort_req);
    load_ok  = load_req && (after_fl < lim);
    cnt_d    = stall_evt ? '0 : (load_ok ? after_fl + ONE_C : after_fl);
    if (stall_evt || flush_req) rdy_d = 1'b0;
    else if (load_ok)           rdy_d = ((after_fl + ONE_C) == lim);
    else if (done_evt)          rdy_d = 1'b0;
    else                        rdy_d = rdy_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      rdy_q <= 1'b0;
      ptr_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      rdy_q <= rdy_d;
      ptr_q <= stall_evt || flush_req;
    end
  end

  assign cnt     = cnt_q;
  assign pkt_rdy = rdy_q;
  assign ptr_rst = ptr_q;

  AST_CNT_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= MAX_C); // R3
  AST_STALL_FLUSH: assert property (@(posedge clk) disable iff (!rst_n)
    stall_evt |=> (cnt_q == '0) && !rdy_q && ptr_q); // R6
  AST_DONE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (done_evt && !load_req) |=> !rdy_q); // R4
  AST_FLUSH_PTR: assert property (@(posedge clk) disable iff (!rst_n)
    flush_req |=> ptr_q && !rdy_q); // R7
endmodule

// File: rtl/usb_inep_tokresp.sv
module usb_inep_tokresp
  import usb_inep_pkg::*;
#(
  parameter int PART_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_tok,
  input  logic              sof_evt,
  input  logic              cfg_iso,
  input  logic [PART_W-1:0] cfg_parts,
  input  logic              stall_req,
  input  logic              have_pkt,
  output logic              hb_mode,
  output logic              stall_evt,
  output logic              data_evt,
  output logic              under_evt,
  output logic              incomp_set,
  output logic              rsp_vld,
  output logic [1:0]        rsp_code
);
  localparam logic [PART_W-1:0] P_ONE = PART_W'(1);

  function automatic logic [PART_W-1:0] part_next(logic [PART_W-1:0] p, logic [PART_W-1:0] n);
    return ((p + P_ONE) == n) ? '0 : p + P_ONE;
  endfunction

  logic [PART_W-1:0] part_q;
  rsp_e              rsp_d;
  logic              vld_q;
  logic [1:0]        code_q;

  always_comb begin
    hb_mode    = cfg_iso && (cfg_parts > P_ONE);
    stall_evt  = in_tok && !cfg_iso && stall_req;
    data_evt   = in_tok && !stall_evt && have_pkt;
    under_evt  = in_tok && !stall_evt && !have_pkt;
    incomp_set = sof_evt && hb_mode && (part_q != '0);
    if (stall_evt)     rsp_d = RSP_STALL;
    else if (data_evt) rsp_d = RSP_DATA;
    else if (in_tok)   rsp_d = RSP_EMPTY;
    else               rsp_d = RSP_NONE;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      part_q <= '0;
      vld_q  <= 1'b0;
      code_q <= 2'd0;
    end else begin
      vld_q  <= in_tok;
      code_q <= rsp_d;
      if (sof_evt)                  part_q <= '0;
      else if (data_evt && hb_mode) part_q <= part_next(part_q, cfg_parts);
    end
  end

  assign rsp_vld  = vld_q;
  assign rsp_code = code_q;

  AST_ISO_NO_STALL: assert property (@(posedge clk) disable iff (!rst_n)
    (in_tok && cfg_iso) |=> (code_q != RSP_STALL)); // R6
  AST_RSP_FOLLOWS_TOK: assert property (@(posedge clk) disable iff (!rst_n)
    in_tok |=> vld_q); // R8
  AST_EMPTY_CODE: assert property (@(posedge clk) disable iff (!rst_n)
    (in_tok && !have_pkt && !(stall_req && !cfg_iso)) |=> (code_q == RSP_EMPTY)); // R8
  AST_PART_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    hb_mode |-> (part_q < cfg_parts)); // R10
endmodule

// File: rtl/usb_inep_csr.sv
module usb_inep_csr
  import usb_inep_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr,
  input  logic [7:0] wdata,
  input  logic       stall_evt,
  input  logic       under_evt,
  input  logic       incomp_set,
  input  logic       done_evt,
  input  logic       flush_req,
  input  logic       cfg_iso,
  input  logic       hb_mode,
  input  logic       irq_en,
  input  logic       cnt_nz,
  input  logic       pkt_rdy,
  output logic       stall_req,
  output logic       data_tog,
  output logic       irq,
  output logic [7:0] rdata
);
  logic sreq_q, sent_q, under_q, inc_q, tog_q, irq_q;
  logic unused_wbits;
  assign unused_wbits = ^{wdata[B_NEMPTY], wdata[B_PKTRDY], wdata[B_FLUSH]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sreq_q  <= 1'b0;
      sent_q  <= 1'b0;
      under_q <= 1'b0;
      inc_q   <= 1'b0;
      tog_q   <= 1'b0;
      irq_q   <= 1'b0;
    end else begin
      if (wr) sreq_q <= wdata[B_STALLREQ];
      sent_q  <= sticky_next(sent_q,  stall_evt,  wr, wdata[B_STALLED]);
      under_q <= sticky_next(under_q, under_evt,  wr, wdata[B_UNDER]);
      inc_q   <= sticky_next(inc_q,   incomp_set, wr, wdata[B_INCOMP]);
      if (wr && wdata[B_TOGCLR])   tog_q <= 1'b0;
      else if (done_evt && !cfg_iso) tog_q <= ~tog_q;
      irq_q <= irq_en && (done_evt || flush_req);
    end
  end

  always_comb begin
    rdata             = '0;
    rdata[B_INCOMP]   = inc_q && hb_mode;
    rdata[B_STALLED]  = sent_q;
    rdata[B_STALLREQ] = sreq_q;
    rdata[B_UNDER]    = under_q;
    rdata[B_NEMPTY]   = cnt_nz;
    rdata[B_PKTRDY]   = pkt_rdy;
  end

  assign stall_req = sreq_q;
  assign data_tog  = tog_q;
  assign irq       = irq_q;

  AST_TOG_CLR: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && wdata[B_TOGCLR]) |=> !tog_q); // R5
  AST_UNDER_SET: assert property (@(posedge clk) disable iff (!rst_n)
    under_evt |=> under_q); // R8
  AST_SENT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (sent_q && !(wr && !wdata[B_STALLED])) |=> sent_q); // R9
  AST_IRQ_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    !irq_en |=> !irq_q); // R4
endmodule

// File: rtl/usb_in_ep_ctl.sv
module usb_in_ep_ctl
  import usb_inep_pkg::*;
#(
  parameter int MAX_PKTS = 2,
  parameter int PART_W   = 2,
  localparam int CNT_W   = $clog2(MAX_PKTS + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cpu_wr,
  input  logic [7:0]        cpu_wdata,
  output logic [7:0]        cpu_rdata,
  input  logic              cfg_iso,
  input  logic [PART_W-1:0] cfg_parts,
  input  logic              cfg_dbl,
  input  logic              cfg_irq_en,
  input  logic              in_tok,
  input  logic              tx_done,
  input  logic              sof_evt,
  output logic              rsp_vld,
  output logic [1:0]        rsp_code,
  output logic              data_tog,
  output logic              fifo_ptr_rst,
  output logic              irq
);
  // named internal events
  logic load_req, flush_req, abort_req;
  logic stall_req, stall_evt, data_evt, under_evt, incomp_set, hb_mode;
  logic pkt_rdy, cnt_nz;
  logic [CNT_W-1:0] cnt;

  assign flush_req = cpu_wr && cpu_wdata[B_FLUSH];
  assign abort_req = flush_req && cpu_wdata[B_PKTRDY];
  assign load_req  = cpu_wr && cpu_wdata[B_PKTRDY] && !cpu_wdata[B_FLUSH];
  assign cnt_nz    = (cnt != '0);

  usb_inep_tokresp #(.PART_W(PART_W)) u_tok (
    .clk(clk), .rst_n(rst_n), .in_tok(in_tok), .sof_evt(sof_evt),
    .cfg_iso(cfg_iso), .cfg_parts(cfg_parts), .stall_req(stall_req),
    .have_pkt(cnt_nz), .hb_mode(hb_mode), .stall_evt(stall_evt),
    .data_evt(data_evt), .under_evt(under_evt), .incomp_set(incomp_set),
    .rsp_vld(rsp_vld), .rsp_code(rsp_code)
  );

  usb_inep_bufcnt #(.MAX_PKTS(MAX_PKTS)) u_buf (
    .clk(clk), .rst_n(rst_n), .cfg_dbl(cfg_dbl), .load_req(load_req),
    .flush_req(flush_req), .abort_req(abort_req), .done_evt(tx_done),
    .stall_evt(stall_evt), .cnt(cnt), .pkt_rdy(pkt_rdy), .ptr_rst(fifo_ptr_rst)
  );

  usb_inep_csr u_csr (
    .clk(clk), .rst_n(rst_n), .wr(cpu_wr), .wdata(cpu_wdata),
    .stall_evt(stall_evt), .under_evt(under_evt), .incomp_set(incomp_set),
    .done_evt(tx_done), .flush_req(flush_req), .cfg_iso(cfg_iso),
    .hb_mode(hb_mode), .irq_en(cfg_irq_en), .cnt_nz(cnt_nz), .pkt_rdy(pkt_rdy),
    .stall_req(stall_req), .data_tog(data_tog), .irq(irq), .rdata(cpu_rdata)
  );

  AST_NE_MATCHES: assert property (@(posedge clk) disable iff (!rst_n)
    pkt_rdy |-> cpu_rdata[B_NEMPTY]); // R11
  AST_DATA_NEEDS_PKT: assert property (@(posedge clk) disable iff (!rst_n)
    data_evt |-> cnt_nz); // R8
endmodule

// File: tb/sim_usb_in_ep_ctl.sv
`timescale 1ns/1ps
module sim_usb_in_ep_ctl;
  logic       clk = 1'b0, rst_n = 1'b0;
  logic       cpu_wr = 1'b0;
  logic [7:0] cpu_wdata = '0;
  logic [7:0] cpu_rdata;
  logic       cfg_iso = 1'b0, cfg_dbl = 1'b0, cfg_irq_en = 1'b1;
  logic [1:0] cfg_parts = 2'd1;
  logic       in_tok = 1'b0, tx_done = 1'b0, sof_evt = 1'b0;
  logic       rsp_vld, data_tog, fifo_ptr_rst, irq;
  logic [1:0] rsp_code;

  usb_in_ep_ctl u0 (.*);

  always #2 clk = ~clk;

  int n_chk = 0, n_bad = 0;
  // bench model state
  int m_cnt, m_parts;
  bit m_rdy, m_ss, m_sent, m_und, m_inc, m_tog, m_vld, m_ptr, m_irq;
  int m_rsp;

  task automatic chk(string tag, string what, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  function automatic bit hb();
    return cfg_iso && cfg_parts > 2'd1;
  endfunction

  function automatic int dec0(int v, bit en);
    return (en && v > 0) ? v - 1 : v;
  endfunction

  function automatic logic [7:0] exp_rd();
    return {m_inc && hb(), 1'b0, m_sent, m_ss, 1'b0, m_und, m_cnt != 0, m_rdy};
  endfunction

  task automatic model_reset();
    m_cnt = 0; m_parts = 0; m_rdy = 0; m_ss = 0; m_sent = 0; m_und = 0;
    m_inc = 0; m_tog = 0; m_vld = 0; m_ptr = 0; m_irq = 0; m_rsp = 0;
  endtask

  task automatic cycle(string tag, bit wr, logic [7:0] wd, bit tok, bit done, bit sof);
    int lim, c;
    bit st, dat, und, fl, ab, ld, la;
    @(negedge clk);
    cpu_wr = wr; cpu_wdata = wd; in_tok = tok; tx_done = done; sof_evt = sof;
    lim = cfg_dbl ? 2 : 1;
    st  = tok && !cfg_iso && m_ss;
    dat = tok && !st && m_cnt > 0;
    und = tok && !st && m_cnt == 0;
    fl  = wr && wd[3];
    ab  = fl && wd[0];
    ld  = wr && wd[0] && !wd[3];
    c = dec0(m_cnt, done);
    c = dec0(c, fl && !ab);
    la = ld && c < lim;
    if (la) c++;
    if (st || fl)    m_rdy = 0;
    else if (la)     m_rdy = (c == lim);
    else if (done)   m_rdy = 0;
    m_cnt = st ? 0 : c;
    m_sent = st ? 1 : (wr && !wd[5]) ? 0 : m_sent;
    m_und  = und ? 1 : (wr && !wd[2]) ? 0 : m_und;
    if (sof && hb() && m_parts != 0) m_inc = 1;
    else if (wr && !wd[7]) m_inc = 0;
    if (sof) m_parts = 0;
    else if (dat && hb()) m_parts = (m_parts + 1 == int'(cfg_parts)) ? 0 : m_parts + 1;
    if (wr) m_ss = wd[4];
    if (wr && wd[6]) m_tog = 0;
    else if (done && !cfg_iso) m_tog = ~m_tog;
    m_vld = tok;
    m_rsp = st ? 2 : dat ? 1 : tok ? 3 : 0;
    m_ptr = st || fl;
    m_irq = cfg_irq_en && (done || fl);
    @(posedge clk); #1;
    cpu_wr = 0; cpu_wdata = '0; in_tok = 0; tx_done = 0; sof_evt = 0;
    chk(tag, "rdata", cpu_rdata, exp_rd());
    chk(tag, "rsp_vld", rsp_vld, m_vld);
    chk(tag, "rsp_code", rsp_code, m_rsp);
    chk(tag, "data_tog", data_tog, m_tog);
    chk(tag, "fifo_ptr_rst", fifo_ptr_rst, m_ptr);
    chk(tag, "irq", irq, m_irq);
  endtask

  task automatic do_reset(bit iso, logic [1:0] parts, bit dbl, bit en);
    @(negedge clk);
    rst_n = 0;
    cfg_iso = iso; cfg_parts = parts; cfg_dbl = dbl; cfg_irq_en = en;
    repeat (3) @(negedge clk);
    rst_n = 1;
    model_reset();
    #1;
    chk("R1", "reset rdata", cpu_rdata, 8'h00);
    chk("R1", "reset tog", data_tog, 0);
    chk("R1", "reset irq/ptr/vld", {irq, fifo_ptr_rst, rsp_vld}, 0);
  endtask

  task automatic rnd_phase(bit iso, logic [1:0] parts, bit dbl, bit en, int n);
    do_reset(iso, parts, dbl, en);
    for (int i = 0; i < n; i++) begin
      bit wr, tok, done, sof;
      logic [7:0] wd;
      wr   = ($urandom % 5) == 0;
      wd   = 8'($urandom);
      tok  = ($urandom % 5) == 0;
      done = !tok && m_cnt > 0 && ($urandom % 4) == 0;
      sof  = !tok && ($urandom % 30) == 0;
      cycle("R2", wr, wd, tok, done, sof);
    end
  endtask

  initial begin
    #(4 * 150000);
    n_bad++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    // single buffer, bulk
    do_reset(0, 2'd1, 0, 1);
    cycle("R1", 0, 8'h00, 0, 0, 0);
    cycle("R3", 1, 8'h01, 0, 0, 0);          // load: ready=1, not-empty=1
    chk("R11", "not-empty bit", cpu_rdata[1], 1);
    cycle("R3", 1, 8'h01, 0, 0, 0);          // full: ignored
    cycle("R8", 0, 8'h00, 1, 0, 0);          // DATA response
    cycle("R4", 0, 8'h00, 0, 1, 0);          // sent: tog flip, irq
    chk("R4", "toggle after send", data_tog, 1);
    cycle("R8", 0, 8'h00, 1, 0, 0);          // empty -> underrun
    chk("R8", "empty code", rsp_code, 3);
    cycle("R9", 1, 8'h04, 0, 0, 0);          // write 1: ignored
    chk("R9", "underrun kept", cpu_rdata[2], 1);
    cycle("R9", 1, 8'h00, 0, 0, 0);          // write 0: clears
    cycle("R9", 1, 8'h00, 1, 0, 0);          // set wins over clear
    chk("R9", "set beats clear", cpu_rdata[2], 1);
    cycle("R6", 1, 8'h11, 0, 0, 0);          // stall request + load
    cycle("R6", 0, 8'h00, 1, 0, 0);          // STALL, flush
    chk("R6", "stall code", rsp_code, 2);
    chk("R6", "stall flushed", cpu_rdata[1:0], 0);
    cycle("R6", 1, 8'h20, 0, 0, 0);          // end stall, keep sent
    cycle("R5", 1, 8'h01, 0, 0, 0);
    cycle("R5", 1, 8'h40, 0, 1, 0);          // clear beats flip
    chk("R5", "toggle cleared", data_tog, 0);
    // double buffer
    do_reset(0, 2'd1, 1, 1);
    cycle("R3", 1, 8'h01, 0, 0, 0);
    chk("R3", "ready early clear", cpu_rdata[1:0], 2'b10);
    cycle("R3", 1, 8'h01, 0, 0, 0);
    chk("R3", "ready when full", cpu_rdata[1:0], 2'b11);
    cycle("R7", 1, 8'h08, 0, 0, 0);          // flush latest
    chk("R7", "one left", cpu_rdata[1:0], 2'b10);
    cycle("R7", 1, 8'h09, 0, 0, 0);          // abort load
    chk("R7", "abort keeps queue", cpu_rdata[1:0], 2'b10);
    // isochronous: stall ignored, no toggle flip
    do_reset(1, 2'd1, 0, 0);
    cycle("R6", 1, 8'h11, 0, 0, 0);
    cycle("R6", 0, 8'h00, 1, 0, 0);
    chk("R6", "iso ignores stall", rsp_code, 1);
    cycle("R4", 0, 8'h00, 0, 1, 0);
    cycle("R10", 0, 8'h00, 1, 0, 0);
    cycle("R10", 0, 8'h00, 0, 0, 1);
    chk("R10", "no incomplete in plain iso", cpu_rdata[7], 0);
    // high-bandwidth iso
    do_reset(1, 2'd3, 0, 1);
    cycle("R10", 1, 8'h01, 0, 0, 0);
    cycle("R10", 0, 8'h00, 1, 0, 0);
    cycle("R10", 0, 8'h00, 0, 0, 1);
    chk("R10", "incomplete set", cpu_rdata[7], 1);
    cycle("R10", 1, 8'h80, 0, 0, 0);
    chk("R10", "write 1 ignored", cpu_rdata[7], 1);
    cycle("R10", 1, 8'h00, 0, 0, 0);
    chk("R10", "write 0 clears", cpu_rdata[7], 0);
    // random phases
    rnd_phase(0, 2'd1, 0, 1, 3000);
    rnd_phase(0, 2'd1, 1, 1, 3000);
    rnd_phase(1, 2'd1, 1, 0, 2000);
    rnd_phase(1, 2'd3, 1, 1, 3000);
    rnd_phase(1, 2'd2, 0, 1, 2000);
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule